// File: doc/BRIEF.md
# Round-Robin Time-Slice Scheduler

This block shares one execution resource among up to `NUM_TASKS` tasks of equal priority. Software or an upstream unit posts a task with an amount of work, counted in time units. The scheduler keeps the posted tasks in a cyclic ready queue and hands the resource to the task at the head. A `tick` strobe marks one elapsed time unit. Each tick uses up one unit of the running task's work and one unit of its slice. When the slice runs out, a slice interrupt pulses, the task goes to the back of the cycle, and the next task takes over. When a task uses up its work, it leaves the cycle and a per-task done pulse is raised.

A higher-priority request (`hp_req`) takes the resource away from the cycle for as long as it is held. The interrupted task keeps its place and its used slice count, and it resumes exactly where it stopped. The slice length comes from an input that is sampled each time a slice starts.

The controller has three states. `ST_IDLE` means no task holds the resource. `ST_RUN` means a task is running. `ST_HELD` means a running task is frozen by a higher-priority request. The transitions are:
- grant: `ST_IDLE` to `ST_RUN`, when the queue is non-empty and `hp_req` is low.
- preempt: `ST_RUN` to `ST_HELD`, when `hp_req` is high.
- drain: `ST_RUN` to `ST_IDLE`, when the last unit finishes and the queue is empty.
- resume: `ST_HELD` to `ST_RUN`, when `hp_req` falls.
- handoff and rotate: these stay in `ST_RUN` and change the active task.

Top module: `rr_slice_sched`

## Requirements
- R1: After reset, `run_valid`, `slice_irq` and `task_done` are all 0.
- R2: A tick in `ST_RUN` with `hp_req` low consumes one work unit and one slice unit of the active task. `run_id` carries the task index and changes only at a grant, a handoff or a rotation.
- R3: When a tick completes the S-th slice unit of a slice and the task still has work left, `slice_irq` is high for exactly the one cycle after that clock edge. At that same edge the task is appended to the tail of the queue and the head task is granted with a zeroed slice count. S is the sampled slice length.
- R4: An `add_valid` cycle appends `add_id` at the queue tail with its work set to `add_work` and its slice count zero. The request is ignored when that task is already queued or running, or when `add_work` is 0.
- R5: A tick that consumes a task's last unit pulses `task_done` bit i for one cycle, where bit i belongs to task i. It raises no `slice_irq`, removes the task from the cycle, and grants the queue head at the same edge.
- R6: If the queue was empty before the expiry edge, the expiring task is granted again. `run_valid` stays high with no idle cycle, and `slice_irq` still pulses.
- R7: While `hp_req` is high, `run_valid` is low and ticks are ignored. When `hp_req` falls, the same task resumes with its used slice count preserved, so it expires after only the remaining units.
- R8: `slice_len` is sampled when a slice starts, whether at a grant, a handoff or a rotation. A change in mid-slice takes effect only at the next slice. A value of 0 acts as 1.
- R9: If a new task is accepted at the same edge where the active task rotates, the new task is queued ahead of the rotated one.
- R10: With no active task, a non-empty queue and `hp_req` low, the head task is granted at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One elapsed time unit |
| hp_req | input | 1 | Higher-priority request; holds the resource away from the cycle |
| add_valid | input | 1 | Post a new task |
| add_id | input | IDW | Index of the posted task |
| add_work | input | WORK_W | Work units of the posted task |
| slice_len | input | CNT_W | Slice length in ticks, sampled at slice start |
| run_valid | output | 1 | A task holds the resource |
| run_id | output | IDW | Index of the task holding the resource |
| slice_irq | output | 1 | One-cycle pulse on slice expiry |
| task_done | output | NUM_TASKS | One-cycle per-task completion pulses |

## Verification
The assertions assume the following about the inputs:
- `add_id` always names an existing task slot. The bench uses four tasks with a two-bit index, so every value is legal.
- A task is never posted while it is queued or running, except where the bench posts a duplicate on purpose to observe that it is ignored.
- `hp_req` changes only on a clock edge.

Under these conditions the queue never holds more entries than tasks and is never popped while empty. The bench keeps each add, tick and preempt in its own cycle of a four-cycle unit, except in one directed case that exercises the same-edge ordering. It also never posts in the same cycle as a single-task rotation, because there the pre-edge queue state decides the outcome.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HELD = 2'd2
    } sched_state_e;
endpackage

// File: rtl/rrs_ready_fifo.sv
module rrs_ready_fifo #(
    parameter int DEPTH = 4,
    parameter int IDW   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_a,
    input  logic [IDW-1:0]               id_a,
    input  logic                         push_b,
    input  logic [IDW-1:0]               id_b,
    input  logic                         pop,
    output logic [IDW-1:0]               head_id,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CQ = $clog2(DEPTH + 1);

    logic [IDW-1:0] slot [DEPTH];
    logic [PW-1:0]  rd_ptr, wr_ptr, wr_b_ptr;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [1:0] k);
        int unsigned s;
        s = int'(p) + int'(k);
        if (s >= DEPTH) s = s - DEPTH;
        return s[PW-1:0];
    endfunction

    // second push lands behind the first one in the same cycle
    assign wr_b_ptr = push_a ? adv(wr_ptr, 2'd1) : wr_ptr;
    assign head_id  = slot[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_a) slot[wr_ptr]   <= id_a;
        if (push_b) slot[wr_b_ptr] <= id_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= adv(wr_ptr, {1'b0, push_a} + {1'b0, push_b});
            rd_ptr <= pop ? adv(rd_ptr, 2'd1) : rd_ptr;
            count  <= count + CQ'(push_a) + CQ'(push_b) - CQ'(pop);
        end
    end

    // R4
    fifo_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) + int'(push_a) + int'(push_b) - int'(pop)) <= DEPTH);
    // R10
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/rrs_slice_timer.sv
module rrs_slice_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] slice_len,
    output logic             expire
);
    logic [CNT_W-1:0] used, limit;
    logic [CNT_W:0]   used_inc;

    assign used_inc = {1'b0, used} + 1'b1;
    assign expire   = step && (used_inc >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used  <= '0;
            limit <= CNT_W'(1);
        end else if (load) begin
            used  <= '0;
            limit <= (slice_len == '0) ? CNT_W'(1) : slice_len;
        end else if (step) begin
            used  <= expire ? '0 : used_inc[CNT_W-1:0];
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) && (used < limit));
    // R7
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(used));
endmodule

// File: rtl/rr_slice_sched.sv
module rr_slice_sched
    import rrs_pkg::*;
#(
    parameter int NUM_TASKS = 4,
    parameter int WORK_W    = 8,
    parameter int CNT_W     = 8,
    parameter int IDW       = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 hp_req,
    input  logic                 add_valid,
    input  logic [IDW-1:0]       add_id,
    input  logic [WORK_W-1:0]    add_work,
    input  logic [CNT_W-1:0]     slice_len,
    output logic                 run_valid,
    output logic [IDW-1:0]       run_id,
    output logic                 slice_irq,
    output logic [NUM_TASKS-1:0] task_done
);
    localparam int CQ = $clog2(NUM_TASKS + 1);

    sched_state_e          state, state_nxt;
    logic [IDW-1:0]        active_id, q_head;
    logic [CQ-1:0]         q_cnt;
    logic [NUM_TASKS-1:0]  busy;
    logic [WORK_W-1:0]     rem_bus [NUM_TASKS];
    logic [WORK_W-1:0]     act_rem;
    logic step, last, expire, accept_new, requeue, grant_idle, handoff, pop, load;

    assign act_rem    = rem_bus[active_id];
    assign step       = (state == ST_RUN) && tick && !hp_req;
    assign last       = step && (act_rem == WORK_W'(1));
    assign accept_new = add_valid && !busy[add_id] && (add_work != '0);
    assign requeue    = expire && !last && (q_cnt != '0);
    assign grant_idle = (state == ST_IDLE) && !hp_req && (q_cnt != '0);
    assign handoff    = last && (q_cnt != '0);
    assign pop        = grant_idle || requeue || handoff;
    assign load       = grant_idle || handoff || (expire && !last);

    rrs_ready_fifo #(.DEPTH(NUM_TASKS), .IDW(IDW)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_a(accept_new), .id_a(add_id),
        .push_b(requeue),    .id_b(active_id),
        .pop(pop), .head_id(q_head), .count(q_cnt)
    );

    rrs_slice_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .slice_len(slice_len), .expire(expire)
    );

    for (genvar gi = 0; gi < NUM_TASKS; gi++) begin : g_task
        logic [WORK_W-1:0] rem;
        logic              live;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rem  <= '0;
                live <= 1'b0;
            end else if (accept_new && (add_id == IDW'(gi))) begin
                rem  <= add_work;
                live <= 1'b1;
            end else if (step && (active_id == IDW'(gi))) begin
                rem  <= rem - 1'b1;
                if (last) live <= 1'b0;
            end
        end
        assign rem_bus[gi] = rem;
        assign busy[gi]    = live;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (grant_idle) state_nxt = ST_RUN;
            ST_RUN: begin
                if (hp_req)                        state_nxt = ST_HELD;
                else if (last && (q_cnt == '0))    state_nxt = ST_IDLE;
            end
            ST_HELD: if (!hp_req) state_nxt = ST_RUN;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs and active task
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_id <= '0;
            slice_irq <= 1'b0;
            task_done <= '0;
        end else begin
            if (pop) active_id <= q_head;
            slice_irq <= expire && !last;
            task_done <= last ? (NUM_TASKS'(1) << active_id) : '0;
        end
    end

    assign run_valid = (state == ST_RUN);
    assign run_id    = active_id;

    // R5
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(task_done));
    // R3
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slice_irq |-> (task_done == '0));
    // R6
    irq_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slice_irq |-> run_valid);
    // R7
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD) |=> ((task_done == '0) && !slice_irq));
    // R7
    held_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HELD) && !hp_req) |=> (run_valid && $stable(run_id)));
endmodule

// File: tb/rr_slice_sched_tb.sv
module rr_slice_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int IDW = 2;
    localparam int WORK_W = 8;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n, tick, hp_req, add_valid;
    logic [IDW-1:0] add_id;
    logic [WORK_W-1:0] add_work;
    logic [CNT_W-1:0] slice_len;
    logic run_valid, slice_irq;
    logic [IDW-1:0] run_id;
    logic [N-1:0] task_done;

    rr_slice_sched #(.NUM_TASKS(N), .WORK_W(WORK_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hp_req(hp_req),
        .add_valid(add_valid), .add_id(add_id), .add_work(add_work),
        .slice_len(slice_len), .run_valid(run_valid), .run_id(run_id),
        .slice_irq(slice_irq), .task_done(task_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int m_act, m_cnt, m_cur, unit_no;
    int m_work [N];
    bit m_busy [N];
    int mq [$];
    int irq_units [$];
    int done_at [N];
    bit exp_irq;
    bit [N-1:0] exp_done;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s unit=%0d actual=%0d expected=%0d", tag, unit_no, act, exp);
        end
    endtask

    function automatic int cur_slice();
        return (slice_len == '0) ? 1 : int'(slice_len);
    endfunction

    task automatic model_grant(bit hp);
        if (m_act < 0 && mq.size() > 0 && !hp) begin
            m_act = mq.pop_front(); m_cnt = 0; m_cur = cur_slice();
        end
    endtask

    task automatic model_add(int id, int w);
        if (!m_busy[id] && w != 0) begin
            m_busy[id] = 1'b1; m_work[id] = w; mq.push_back(id);
        end
    endtask

    task automatic model_tick();
        if (m_act < 0) return;
        m_work[m_act]--;
        if (m_work[m_act] == 0) begin
            exp_done[m_act] = 1'b1; m_busy[m_act] = 1'b0; m_act = -1;
            if (mq.size() > 0) begin m_act = mq.pop_front(); m_cnt = 0; m_cur = cur_slice(); end
        end else begin
            m_cnt++;
            if (m_cnt >= m_cur) begin
                exp_irq = 1'b1; m_cnt = 0; m_cur = cur_slice();
                if (mq.size() > 0) begin mq.push_back(m_act); m_act = mq.pop_front(); end
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 0; hp_req = 0; add_valid = 0; add_id = '0; add_work = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_act = -1; m_cnt = 0; m_cur = 1; unit_no = 0;
        mq.delete(); irq_units.delete();
        for (int i = 0; i < N; i++) begin m_work[i] = 0; m_busy[i] = 0; done_at[i] = -1; end
        #1;
        check("R1 run_valid", int'(run_valid), 0);
        check("R1 slice_irq", int'(slice_irq), 0);
        check("R1 task_done", int'(task_done), 0);
    endtask

    // one time unit: add cycle, grant cycle, tick cycle, settle cycle
    task automatic unit(bit hp, int aid, int aw, bit add_with_tick);
        @(negedge clk);
        hp_req = hp;
        if (aid >= 0 && !add_with_tick) begin
            add_valid = 1; add_id = IDW'(aid); add_work = WORK_W'(aw);
        end
        @(posedge clk);
        if (aid >= 0 && !add_with_tick) model_add(aid, aw);
        @(negedge clk);
        add_valid = 0;
        @(posedge clk);
        model_grant(hp);
        @(negedge clk);
        tick = 1;
        if (aid >= 0 && add_with_tick) begin
            add_valid = 1; add_id = IDW'(aid); add_work = WORK_W'(aw);
        end
        @(posedge clk);
        exp_irq = 0; exp_done = '0;
        if (aid >= 0 && add_with_tick) model_add(aid, aw);
        if (!hp) model_tick();
        #1;
        check("R3 slice_irq", int'(slice_irq), int'(exp_irq));
        check("R5 task_done", int'(task_done), int'(exp_done));
        if (slice_irq) irq_units.push_back(unit_no);
        for (int i = 0; i < N; i++) if (task_done[i]) done_at[i] = unit_no;
        @(negedge clk);
        tick = 0; add_valid = 0;
        @(posedge clk);
        model_grant(hp);
        #1;
        check("R2 R7 R10 run_valid", int'(run_valid), int'(m_act >= 0 && !hp));
        if (run_valid) check("R2 R6 run_id", int'(run_id), m_act);
        unit_no++;
    endtask

    initial begin
        slice_len = CNT_W'(2);
        do_reset();

        // worked example: slice 2, three tasks of 3 units
        unit(0, 0, 3, 0); unit(0, 1, 3, 0); unit(0, -1, 0, 0); unit(0, 2, 3, 0);
        for (int u = 4; u < 10; u++) unit(0, -1, 0, 0);
        check("R5 task0 done unit", done_at[0], 4);
        check("R3 task1 done unit", done_at[1], 7);
        check("R3 task2 done unit", done_at[2], 8);
        check("R3 first expiry unit", irq_units.size() > 0 ? irq_units[0] : -1, 1);

        // R7: preempt mid-slice, remaining units preserved
        slice_len = CNT_W'(3);
        do_reset();
        unit(0, 0, 9, 0); unit(1, -1, 0, 0); unit(0, -1, 0, 0); unit(0, -1, 0, 0);
        check("R7 expiry after resume", irq_units.size() > 0 ? irq_units[0] : -1, 3);
        check("R6 regrant keeps run_valid", int'(run_valid), 1);
        check("R6 regrant same task", int'(run_id), 0);

        // R8: mid-slice change applies to the next slice
        slice_len = CNT_W'(2);
        do_reset();
        unit(0, 0, 20, 0);
        slice_len = CNT_W'(4);
        for (int u = 1; u < 7; u++) unit(0, -1, 0, 0);
        check("R8 first expiry unit", irq_units.size() > 0 ? irq_units[0] : -1, 1);
        check("R8 second expiry unit", irq_units.size() > 1 ? irq_units[1] : -1, 5);

        // R9: add at the same edge as a rotation
        slice_len = CNT_W'(1);
        do_reset();
        unit(0, 0, 5, 0); unit(0, 1, 5, 0); unit(0, 2, 5, 1); unit(0, -1, 0, 0);
        check("R9 new task ahead of rotated", int'(run_id), 2);

        // R4: duplicate and zero-work adds ignored; R10 grant from idle
        slice_len = CNT_W'(8);
        do_reset();
        unit(0, 0, 4, 0);
        check("R10 grant from idle", int'(run_valid), 1);
        unit(0, 0, 9, 0); unit(0, 1, 0, 0); unit(0, -1, 0, 0); unit(0, -1, 0, 0);
        check("R4 duplicate ignored, done unit", done_at[0], 3);
        check("R4 zero work ignored, idle", int'(run_valid), 0);

        // sweep: slices 1..4, six arrival/preempt patterns
        for (int s = 1; s <= 4; s++) begin
            for (int pat = 0; pat < 6; pat++) begin
                slice_len = CNT_W'(s);
                do_reset();
                for (int u = 0; u < 40; u++) begin
                    int aid, aw;
                    bit hp;
                    aid = -1; aw = 0;
                    for (int i = 0; i < N; i++) begin
                        if (u == i * (pat % 3 + 1)) begin aid = i; aw = 1 + ((i*3 + pat + s) % 5); end
                        if (u == 20 + i) begin aid = i; aw = (i + pat) % 4; end
                    end
                    if (u == 5) begin aid = 0; aw = 2; end
                    hp = (pat >= 3) && (((u*7 + pat) % 11) == 3);
                    unit(hp, aid, aw, 0);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule